// File: doc/BRIEF.md
# Programmable Interval Timer

This block measures fixed intervals in whole microseconds. Software writes a negative count into a reload register. It then sets the transfer strobe in the control register, which copies that count into a live 32-bit counter. While the run bit is set, the counter steps up by one on every microsecond tick. When it passes from all ones back to zero, one interval has ended: the counter reloads at once from the reload register and a completion flag is raised. An interrupt request is raised as well if interrupts are enabled. If a second interval ends before software has cleared the flag, a sticky error flag records the missed interval.

The microsecond tick either comes in on a pin or is made inside the block by a prescaler. The prescaler divides the system clock by a parameter. With the timer stopped, software can also step the counter by hand, one count per write. Registers are reached through a simple single-cycle write strobe with a combinational read path. Register addresses are 0 for control/status, 1 for the live count and 2 for the reload value.

Top module: `ivl_timer`

## Requirements
- R1: After a synchronous active-low reset, the control/status register (address 0) reads 0, the reload register (address 2) reads 0 and `irq` is 0.
- R2: A control read returns only bit 31 (error), bit 7 (done), bit 6 (interrupt enable) and bit 0 (run). Bit 5 (single step), bit 4 (transfer) and every other bit read as 0.
- R3: A control write with bit 4 set copies the reload register into the count register (address 1). The new value can be read in the cycle after the write.
- R4: While run is 1, the count increases by exactly one for each tick and does not change between ticks. While run is 0, ticks leave it unchanged.
- R5: A step from 0xFFFFFFFF reloads the count from the reload register and sets done (bit 7) when done was clear.
- R6: A step from 0xFFFFFFFF while done is already 1 sets error (bit 31) and leaves done at 1. Error stays set until it is cleared by a write.
- R7: When the count reloads after a tick, `irq` becomes 1 if interrupt enable is 1, and 0 otherwise.
- R8: A control write with bit 5 set and bit 0 clear steps the count by exactly one, with the same flag, reload and interrupt handling as R5 to R7. With bit 0 set, bit 5 has no effect.
- R9: After any control write, `irq` is 0 unless done and interrupt enable are both 1.
- R10: Writing 1 to bit 7 or bit 31 clears that flag. Writing 0 to either bit leaves it unchanged.
- R11: The reload register reads back the value last written to it. Writes to the count address are ignored.
- R12: A control write that sets transfer and run together loads the count first. The first increment comes from the next tick, not from the write cycle itself.
- R13: With the internal prescaler selected, one tick is produced every `PRESCALE` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_in | input | 1 | External microsecond enable, used when `EXT_TICK` is 1 |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 2 | Register address: 0 control, 1 count, 2 reload |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check that `irq` is never high without both done and interrupt enable. They also check that error stays sticky until it is cleared, that every reload leaves done set, that loads and steps move the count exactly as commanded, and that internal ticks are never back to back. The bench scenarios cover what only a sequence of accesses can show. These are the readback masking of the control register, the done-then-error order across two intervals, the single-step path with and without run, the write-one-to-clear behaviour, the ignored write to the count address, and the real tick spacing of the prescaler.

// File: rtl/ivl_timer_pkg.sv
// Package: shared register addresses, control bit positions and widths for
// the interval timer. Assumes a 32-bit register data path.
package ivl_timer_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_COUNT = 2'd1,
        ADDR_NEXT  = 2'd2
    } reg_addr_e;

    // Control/status bit positions (fixed, software decodes them)
    localparam int B_RUN  = 0;
    localparam int B_XFR  = 4;
    localparam int B_SGL  = 5;
    localparam int B_IE   = 6;
    localparam int B_DONE = 7;
    localparam int B_ERR  = 31;

    typedef struct packed {
        logic err;
        logic done;
        logic ie;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/ivl_tick_gen.sv
// Tick generator: delivers a one-cycle microsecond enable.
// EXT_TICK=1 passes the tick_in pin through; EXT_TICK=0 divides clk by
// PRESCALE. Assumes PRESCALE >= 1 and tick_in is already synchronous.
module ivl_tick_gen #(
    parameter bit EXT_TICK = 1'b0,
    parameter int PRESCALE = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic tick
);

    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (EXT_TICK) begin : g_ext
            logic unused_rst;
            assign unused_rst = rst_n;
            assign tick = tick_in;
        end else if (PRESCALE == 1) begin : g_every
            logic unused_in;
            assign unused_in = tick_in ^ rst_n;
            assign tick = 1'b1;
        end else begin : g_div
            logic [PW-1:0] psc_q;
            logic          unused_in;
            assign unused_in = tick_in;

            // Count system clocks modulo PRESCALE
            always_ff @(posedge clk) begin
                if (!rst_n)
                    psc_q <= '0;
                else if (psc_q == PW'(PRESCALE - 1))
                    psc_q <= '0;
                else
                    psc_q <= psc_q + 1'b1;
            end

            assign tick = (psc_q == PW'(PRESCALE - 1));

            a_r13_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("R13: internal ticks back to back");
        end
    endgenerate

endmodule

// File: rtl/ivl_counter.sv
// Interval counter: live count that can be loaded from the reload value
// and stepped by one. A step from all ones wraps by reloading and pulses
// wrap in the same cycle. Assumes load and step may come together: the
// step then applies to the freshly loaded value.
module ivl_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] count,
    output logic         wrap
);

    logic [W-1:0] base;
    logic         at_max;

    // Select the value the step applies to
    always_comb begin
        base   = load ? load_val : count;
        at_max = &base;
        wrap   = step && at_max;
    end

    // Update the live count
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (step)
            count <= at_max ? load_val : base + 1'b1;
        else
            count <= base;
    end

    a_r3_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !step) |=> count == $past(load_val))
        else $error("R3: transfer did not copy reload value");

    a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !(&count)) |=> count == $past(count) + 1'b1)
        else $error("R4: step did not add one");

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(count))
        else $error("R4: count moved without step");

endmodule

// File: rtl/ivl_ctrl.sv
// Register file and control for the interval timer: control/status flags,
// reload register, interrupt request and read mux. Decides when the counter
// loads or steps, and updates done/error/irq on wrap. Assumes a control
// write cycle consumes any tick in that cycle.
module ivl_ctrl
    import ivl_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              tick,
    input  logic              wrap,
    input  logic [DATA_W-1:0] count,
    output logic              load,
    output logic [DATA_W-1:0] next_val,
    output logic              step,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    ctrl_t ctl_q, ctl_n;
    logic  irq_n;
    logic  ctl_wr, next_wr;
    logic  done_kept, err_kept;

    assign ctl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
    assign next_wr = reg_wr && (reg_addr == ADDR_NEXT);

    // Counter commands: transfer/single step on write, else run ticks
    always_comb begin
        load = ctl_wr && reg_wdata[B_XFR];
        if (ctl_wr)
            step = reg_wdata[B_SGL] && !reg_wdata[B_RUN];
        else
            step = tick && ctl_q.run;
    end

    // Next-state of flags and interrupt request
    always_comb begin
        done_kept = ctl_q.done & ~(ctl_wr & reg_wdata[B_DONE]);
        err_kept  = ctl_q.err  & ~(ctl_wr & reg_wdata[B_ERR]);
        ctl_n.run = ctl_wr ? reg_wdata[B_RUN] : ctl_q.run;
        ctl_n.ie  = ctl_wr ? reg_wdata[B_IE]  : ctl_q.ie;
        ctl_n.done = done_kept | (wrap & ~done_kept);
        ctl_n.err  = err_kept  | (wrap &  done_kept);
        if (ctl_wr)
            irq_n = (irq | (wrap & ctl_n.ie)) & ctl_n.done & ctl_n.ie;
        else if (wrap)
            irq_n = ctl_q.ie;
        else
            irq_n = irq;
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            irq      <= 1'b0;
            next_val <= '0;
        end else begin
            ctl_q <= ctl_n;
            irq   <= irq_n;
            if (next_wr)
                next_val <= reg_wdata;
        end
    end

    // Read mux; control reads expose only the four stored flags
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[B_ERR]  = ctl_q.err;
                reg_rdata[B_DONE] = ctl_q.done;
                reg_rdata[B_IE]   = ctl_q.ie;
                reg_rdata[B_RUN]  = ctl_q.run;
            end
            ADDR_COUNT: reg_rdata = count;
            ADDR_NEXT:  reg_rdata = next_val;
            default:    reg_rdata = '0;
        endcase
    end

    a_r9_irq_needs_done_ie: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctl_q.done && ctl_q.ie))
        else $error("R9: irq without done and ie");

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.err && !(ctl_wr && reg_wdata[B_ERR])) |=> ctl_q.err)
        else $error("R6: error flag dropped");

    a_r5_wrap_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ctl_q.done)
        else $error("R5: wrap left done clear");

    a_r7_wrap_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !ctl_wr && ctl_q.ie) |=> irq)
        else $error("R7: wrap with ie did not raise irq");

    a_r10_done_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && reg_wdata[B_DONE] && !wrap) |=> !ctl_q.done)
        else $error("R10: done not cleared by write of one");

endmodule

// File: rtl/ivl_timer.sv
// Interval timer top: ties the tick source, the control/register block and
// the counter together. Assumes registers are accessed with a one-cycle
// write strobe and that reads are combinational.
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter bit EXT_TICK = 1'b0,
    parameter int PRESCALE = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    logic              tick;
    logic              load, step, wrap;
    logic [DATA_W-1:0] next_val, count;

    ivl_tick_gen #(
        .EXT_TICK (EXT_TICK),
        .PRESCALE (PRESCALE)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_in (tick_in),
        .tick    (tick)
    );

    ivl_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .tick      (tick),
        .wrap      (wrap),
        .count     (count),
        .load      (load),
        .next_val  (next_val),
        .step      (step),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    ivl_counter #(
        .W (DATA_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (next_val),
        .step     (step),
        .count    (count),
        .wrap     (wrap)
    );

    a_r11_count_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_COUNT && !step) |=> $stable(count))
        else $error("R11: write to count address changed count");

endmodule

// File: tb/tb_ivl_timer.sv
// Bench for ivl_timer: a vector table walked by one loop, then directed
// tests for reset and the internal prescaler.
module tb_ivl_timer;

    localparam logic [1:0] OP_W = 2'd0;  // write data to addr
    localparam logic [1:0] OP_R = 2'd1;  // compare read of addr
    localparam logic [1:0] OP_T = 2'd2;  // one external tick
    localparam logic [1:0] OP_I = 2'd3;  // compare irq

    function automatic logic [39:0] V(input logic [1:0] op, input logic [1:0] a,
                                      input logic [31:0] d, input logic [3:0] r);
        return {op, a, d, r};
    endfunction

    localparam int NV = 64;
    localparam logic [39:0] VEC [NV] = '{
        V(OP_R,0,32'h0,1),          // R1 control after reset
        V(OP_R,2,32'h0,1),          // R1 reload after reset
        V(OP_I,0,32'h0,1),          // R1 irq after reset
        V(OP_W,2,32'hFFFF_FFFD,0),
        V(OP_R,2,32'hFFFF_FFFD,11), // R11 reload readback
        V(OP_W,1,32'h1234_5678,0),
        V(OP_R,1,32'h0,11),         // R11 count write ignored
        V(OP_W,0,32'h10,0),
        V(OP_R,1,32'hFFFF_FFFD,3),  // R3 transfer
        V(OP_R,0,32'h0,2),          // R2 transfer bit reads 0
        V(OP_T,0,32'h0,0),
        V(OP_R,1,32'hFFFF_FFFD,4),  // R4 no count while stopped
        V(OP_W,0,32'h41,0),
        V(OP_R,0,32'h41,2),         // R2
        V(OP_T,0,32'h0,0),
        V(OP_R,1,32'hFFFF_FFFE,4),  // R4
        V(OP_T,0,32'h0,0),
        V(OP_R,1,32'hFFFF_FFFF,4),  // R4
        V(OP_I,0,32'h0,7),          // R7 no irq before wrap
        V(OP_T,0,32'h0,0),
        V(OP_R,1,32'hFFFF_FFFD,5),  // R5 reload
        V(OP_R,0,32'hC1,5),         // R5 done set
        V(OP_I,0,32'h1,7),          // R7
        V(OP_T,0,32'h0,0),
        V(OP_T,0,32'h0,0),
        V(OP_T,0,32'h0,0),
        V(OP_R,0,32'h8000_00C1,6),  // R6 error on second wrap
        V(OP_R,1,32'hFFFF_FFFD,6),  // R6
        V(OP_I,0,32'h1,7),          // R7
        V(OP_W,0,32'h8000_0041,0),
        V(OP_R,0,32'hC1,10),        // R10 error cleared, done kept
        V(OP_I,0,32'h1,9),          // R9 done and ie both set
        V(OP_W,0,32'h01,0),
        V(OP_I,0,32'h0,9),          // R9 ie cleared drops irq
        V(OP_R,0,32'h81,10),        // R10
        V(OP_W,0,32'h81,0),
        V(OP_R,0,32'h01,10),        // R10 done cleared
        V(OP_W,0,32'h00,0),
        V(OP_W,0,32'h20,0),
        V(OP_R,1,32'hFFFF_FFFE,8),  // R8 single step
        V(OP_R,0,32'h0,2),          // R2 step bit reads 0
        V(OP_W,0,32'h60,0),
        V(OP_R,1,32'hFFFF_FFFF,8),  // R8
        V(OP_W,0,32'h60,0),
        V(OP_R,1,32'hFFFF_FFFD,8),  // R8 step wraps
        V(OP_R,0,32'hC0,8),         // R8
        V(OP_I,0,32'h1,8),          // R8
        V(OP_W,0,32'h21,0),
        V(OP_R,1,32'hFFFF_FFFD,8),  // R8 step ignored while running
        V(OP_I,0,32'h0,9),          // R9
        V(OP_W,2,32'hFFFF_FF00,0),
        V(OP_W,0,32'h91,0),
        V(OP_R,1,32'hFFFF_FF00,12), // R12 load before count
        V(OP_R,0,32'h01,12),        // R12
        V(OP_T,0,32'h0,0),
        V(OP_R,1,32'hFFFF_FF01,12), // R12
        V(OP_W,2,32'hFFFF_FFFF,0),
        V(OP_W,0,32'h11,0),
        V(OP_T,0,32'h0,0),
        V(OP_R,1,32'hFFFF_FFFF,5),  // R5 reload of all ones
        V(OP_R,0,32'h81,5),         // R5
        V(OP_I,0,32'h0,7),          // R7 wrap without ie
        V(OP_W,0,32'hFFFF_FFFF,0),
        V(OP_R,0,32'h41,2)          // R2 only stored bits read back
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        p_wr = 1'b0;
    logic [1:0]  p_addr = 2'd0;
    logic [31:0] p_wdata = '0;
    logic [31:0] p_rdata;
    logic        p_irq;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    ivl_timer #(.EXT_TICK(1'b1), .PRESCALE(50)) dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

    ivl_timer #(.EXT_TICK(1'b0), .PRESCALE(5)) dut_p (
        .clk(clk), .rst_n(rst_n), .tick_in(1'b0), .reg_wr(p_wr),
        .reg_addr(p_addr), .reg_wdata(p_wdata), .reg_rdata(p_rdata), .irq(p_irq));

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] c0, c1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [1:0]  a;
            logic [31:0] d;
            logic [3:0]  r;
            {op, a, d, r} = VEC[i];
            @(negedge clk);
            reg_wr = 1'b0; tick_in = 1'b0;
            case (op)
                OP_W: begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
                OP_T: tick_in = 1'b1;
                OP_R: begin reg_addr = a; #2; check(int'(r), reg_rdata, d); end
                default: begin #2; check(int'(r), {31'b0, irq}, d); end
            endcase
        end
        @(negedge clk);
        reg_wr = 1'b0; tick_in = 1'b0;

        // R8: single step wrap from stopped state raises irq, then R1 reset
        wr(2'd0, 32'h40);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd0, 32'h70);
        #2; check(8, {31'b0, irq}, 32'h1);
        reg_addr = 2'd0; #1; check(8, reg_rdata, 32'hC0);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #2; check(1, {31'b0, irq}, 32'h0);                  // R1
        reg_addr = 2'd0; #1; check(1, reg_rdata, 32'h0);    // R1
        reg_addr = 2'd2; #1; check(1, reg_rdata, 32'h0);    // R1
        @(negedge clk); rst_n = 1'b1;

        // R13: internal prescaler gives one tick every 5 cycles
        @(negedge clk); p_wr = 1'b1; p_addr = 2'd0; p_wdata = 32'h11;
        @(negedge clk); p_wr = 1'b0; p_addr = 2'd1;
        #2; c0 = p_rdata;
        repeat (5) @(negedge clk);
        #2; c1 = p_rdata;
        check(13, c1 - c0, 32'd1);   // R13 one prescaled tick
        repeat (50) @(negedge clk);
        #2; c0 = p_rdata;
        check(13, c0 - c1, 32'd10);  // R13 ten prescaled ticks

        finish_run();
    end

endmodule